// File: doc/BRIEF.md
# Auto-Reload Down-Counting Timer Channel

This block is a single 32-bit timer channel. Its counter steps down once per prescaled tick. When a tick arrives while the counter already holds zero, the counter reloads from a constant register and a sticky underflow flag is set. An interrupt output is that flag gated by an enable bit. Software reaches the channel through a small word-indexed register file. A parent controller drives a `run` input that starts and pauses counting.

A two-state machine follows `run`. The states are `CH_HALTED` and `CH_COUNTING`. The transition START goes from `CH_HALTED` to `CH_COUNTING` when `run` is seen high. The transition PAUSE goes back when `run` is seen low. Only `CH_COUNTING` advances the prescaler and the counter. The control register also holds fields for clock-edge choice, capture enable and a capture flag. These fields are stored and read back, but they change nothing. The capture register is plain storage.

Top module: `reload_timer_channel`

## Requirements
- R1: After reset, index 0 (constant) and index 1 (counter) read 0xFFFFFFFF, index 2 (control) reads 0, index 3 (capture) reads 0 and `irq` is 0.
- R2: Register indices on `addr` are: 0 constant, 1 counter, 2 control, 3 capture. Constant and capture read back what was written, and the counter reads its live value.
- R3: Control bits [2:0] hold the prescaler code. Codes 0, 1, 2, 3 and 4 give one tick per 4, 16, 64, 256 and 1024 counting cycles. Codes 5, 6 and 7 give one tick per 4. A tick falls on every cycle in which the number of counting cycles since reset, taken modulo the divisor, equals divisor-1.
- R4: On a tick the counter decrements. A tick while it holds 0 reloads it from the constant register and sets the underflow flag (control bit 8).
- R5: A write to index 1 loads the counter on the next edge. It overrides a tick in the same cycle, and that cycle then raises no underflow. A write to index 0 changes only the value used at later reloads.
- R6: A control write with bit 8 at 0 clears the flag, and with bit 8 at 1 leaves it as it is. An underflow in the same cycle as a clearing write leaves the flag set.
- R7: `irq` equals the underflow flag ANDed with control bit 5.
- R8: The state follows `run` one edge late. Counting cycles are those in state `CH_COUNTING`. In `CH_HALTED` the counter and the prescaler phase hold their values, and counting resumes from them.
- R9: Control reads return bits [7:0] and bit 9 as last written, the flag in bit 8, and 0 in bits [31:10].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start (1) or pause (0) from the parent controller |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the register at `addr`, combinational |
| irq | output | 1 | Underflow interrupt |

## Verification
The bench aims a flag-clearing write at the exact cycle of an underflow. A design that let the clear win would lose the interrupt. It also aims a counter load at a cycle where the counter holds zero. A design that let the tick win, or raised the flag anyway, would show a reloaded value or a spurious flag. The bench sweeps every prescaler code, including the reserved ones, and pauses `run` mid-count. A design whose prescaler kept running while paused, or that mapped the reserved codes to another rate, would drift away from the bench's reference model. Writing all ones to control exposes any reserved bit that reads back, and any write of 1 that sets the flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NUM_RATES = 5;
    localparam int PRE_W     = 2 * NUM_RATES;

    localparam logic [1:0] IDX_CONST   = 2'd0;
    localparam logic [1:0] IDX_COUNTER = 2'd1;
    localparam logic [1:0] IDX_CONTROL = 2'd2;
    localparam logic [1:0] IDX_CAPTURE = 2'd3;

    localparam int BIT_IE   = 5;
    localparam int BIT_FLAG = 8;
    localparam int BIT_CAPF = 9;

    typedef enum logic {
        CH_HALTED   = 1'b0,
        CH_COUNTING = 1'b1
    } chan_state_e;

    typedef struct packed {
        logic       capf;
        logic [1:0] cape;
        logic       ie;
        logic [1:0] edge_sel;
        logic [2:0] rate;
    } ctrl_fields_t;

    function automatic logic [PRE_W-1:0] rate_mask(input logic [2:0] code);
        logic [PRE_W-1:0] m;
        m = '0;
        if (int'(code) < NUM_RATES) begin
            for (int i = 0; i < PRE_W; i++) begin
                if (i < 2 * (int'(code) + 1)) m[i] = 1'b1;
            end
        end else begin
            m[1:0] = 2'b11;
        end
        return m;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [2:0] rate,
    output logic       tick
);
    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = rate_mask(rate);
        tick = en && ((phase_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  phase_q <= '0;
        else if (en) phase_q <= phase_q + 1'b1;
    end

    a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(phase_q));

endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] cnt,
    output logic         uf
);
    logic [W-1:0] cnt_q;
    logic         at_zero;

    always_comb begin
        at_zero = (cnt_q == '0);
        uf      = tick && at_zero && !load;
        cnt     = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '1;
        else if (load)    cnt_q <= load_val;
        else if (tick)    cnt_q <= at_zero ? reload_val : cnt_q - 1'b1;
    end

    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt_q == '0) |=> cnt_q == $past(reload_val));
    a_r8_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [15:0]  wdata,
    input  logic         uf,
    output ctrl_fields_t fields,
    output logic         flag,
    output logic [15:0]  rd
);
    ctrl_fields_t fields_q;
    logic         flag_q;
    logic         clr_req;

    always_comb begin
        clr_req = wr && !wdata[BIT_FLAG];
        fields  = fields_q;
        flag    = flag_q;
        rd      = '0;
        rd[7:0]      = {fields_q.cape, fields_q.ie, fields_q.edge_sel, fields_q.rate};
        rd[BIT_FLAG] = flag_q;
        rd[BIT_CAPF] = fields_q.capf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields_q <= '0;
        end else if (wr) begin
            fields_q <= '{capf: wdata[BIT_CAPF], cape: wdata[7:6], ie: wdata[BIT_IE],
                          edge_sel: wdata[4:3], rate: wdata[2:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (uf)      flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wdata[BIT_FLAG] && !uf) |=> !flag_q);
    a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr && !wdata[BIT_FLAG])) |=> flag_q);
    a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> flag_q);

endmodule

// File: rtl/reload_timer_channel.sv
module reload_timer_channel
    import tmr_pkg::*;
#(
    parameter int W           = 32,
    parameter bit HAS_CAPTURE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         irq
);
    localparam int CTRL_PAD = W - 16;

    chan_state_e  state_q, state_d;
    logic         count_en;
    logic         tick;
    logic         uf;
    logic         flag;
    logic [W-1:0] const_q;
    logic [W-1:0] cap_q;
    logic [W-1:0] cnt;
    logic [15:0]  ctrl_rd;
    ctrl_fields_t fields;
    logic         wr_const, wr_cnt, wr_ctrl, wr_cap;

    always_comb begin
        wr_const = wr_en && (addr == IDX_CONST);
        wr_cnt   = wr_en && (addr == IDX_COUNTER);
        wr_ctrl  = wr_en && (addr == IDX_CONTROL);
        wr_cap   = wr_en && (addr == IDX_CAPTURE);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_HALTED;
        else        state_q <= state_d;
    end

    // next state: START and PAUSE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALTED:   if (run)  state_d = CH_COUNTING;
            CH_COUNTING: if (!run) state_d = CH_HALTED;
            default:               state_d = CH_HALTED;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        count_en = (state_q == CH_COUNTING);
        irq      = flag && fields.ie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        const_q <= '1;
        else if (wr_const) const_q <= wdata;
    end

    generate
        if (HAS_CAPTURE) begin : g_cap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      cap_q <= '0;
                else if (wr_cap) cap_q <= wdata;
            end
        end else begin : g_nocap
            assign cap_q = '0;
        end
    endgenerate

    tmr_prescaler u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (count_en),
        .rate (fields.rate),
        .tick (tick)
    );

    tmr_downcount #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (wr_cnt),
        .load_val  (wdata),
        .reload_val(const_q),
        .cnt       (cnt),
        .uf        (uf)
    );

    tmr_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_ctrl),
        .wdata (wdata[15:0]),
        .uf    (uf),
        .fields(fields),
        .flag  (flag),
        .rd    (ctrl_rd)
    );

    always_comb begin
        unique case (addr)
            IDX_CONST:   rdata = const_q;
            IDX_COUNTER: rdata = cnt;
            IDX_CONTROL: rdata = {{CTRL_PAD{1'b0}}, ctrl_rd};
            default:     rdata = cap_q;
        endcase
    end

    a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (state_q == CH_COUNTING) == $past(run));
    a_r1_no_early_uf: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HALTED) |-> !uf);

endmodule

// File: tb/reload_timer_channel_bench.sv
module reload_timer_channel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd1;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit live = 0;
    string cur_req = "R1";

    // reference model state
    logic [31:0] m_const, m_cnt, m_cap;
    logic [9:0]  m_ctrl;
    logic        m_flag, m_en;
    int          m_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    reload_timer_channel u_reload_timer_channel (
        .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic int m_div(input logic [2:0] c);
        case (c)
            3'd0: return 4;
            3'd1: return 16;
            3'd2: return 64;
            3'd3: return 256;
            3'd4: return 1024;
            default: return 4;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_const;
            2'd1: return m_cnt;
            2'd2: return {22'd0, m_ctrl[9], m_flag, m_ctrl[7:0]};
            default: return m_cap;
        endcase
    endfunction

    function automatic bit m_uf_next();
        int d;
        d = m_div(m_ctrl[2:0]);
        return m_en && (m_pc % d == d - 1) && (m_cnt == 0);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_const = '1; m_cnt = '1; m_cap = '0; m_ctrl = '0;
            m_flag = 0; m_en = 0; m_pc = 0;
        end else begin
            int d;
            bit tk, ld, ufm;
            d   = m_div(m_ctrl[2:0]);
            tk  = m_en && (m_pc % d == d - 1);
            ld  = wr_en && addr == 2'd1;
            ufm = tk && m_cnt == 0 && !ld;
            if (ufm) m_flag = 1;
            else if (wr_en && addr == 2'd2 && !wdata[8]) m_flag = 0;
            if (ld) m_cnt = wdata;
            else if (tk) m_cnt = (m_cnt == 0) ? m_const : m_cnt - 1;
            if (m_en) m_pc = (m_pc + 1) % 1024;
            if (wr_en && addr == 2'd0) m_const = wdata;
            if (wr_en && addr == 2'd3) m_cap = wdata;
            if (wr_en && addr == 2'd2) m_ctrl = {wdata[9], 1'b0, wdata[7:0]};
            m_en = run;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (live && rst_n && !done) begin
            check(cur_req, rdata, m_read(addr));
            check({cur_req, " R7 irq"}, {31'd0, irq}, {31'd0, m_flag & m_ctrl[5]});
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1; addr = a; wdata = d;
        step(1);
        wr_en = 0; addr = 2'd1;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
        addr = a; #1;
        check(req, rdata, exp);
        #0 addr = 2'd1;
    endtask

    task automatic wait_uf();
        int guard = 0;
        while (!m_uf_next() && guard < 5000) begin step(1); guard++; end
    endtask

    initial begin
        step(2);
        rst_n = 1;
        step(1);
        // R1 reset values
        rd_check("R1 const", 2'd0, 32'hFFFF_FFFF);
        rd_check("R1 counter", 2'd1, 32'hFFFF_FFFF);
        rd_check("R1 control", 2'd2, 32'h0);
        rd_check("R1 capture", 2'd3, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        live = 1;

        // R9 reserved bits and stored-only fields
        cur_req = "R9";
        wr(2'd2, 32'hFFFF_FFFF);
        rd_check("R9 control readback", 2'd2, 32'h0000_02FF);
        wr(2'd2, 32'h0000_0000);

        // R2 register map
        cur_req = "R2";
        wr(2'd0, 32'd10);
        rd_check("R2 const", 2'd0, 32'd10);
        wr(2'd1, 32'd7);
        rd_check("R2 counter", 2'd1, 32'd7);
        wr(2'd3, 32'h1234_5678);
        rd_check("R2 capture", 2'd3, 32'h1234_5678);

        // R4/R7 main counting at divide-by-4
        cur_req = "R4";
        wr(2'd0, 32'd5);
        wr(2'd1, 32'd2);
        wr(2'd2, 32'h0000_0020);
        run = 1;
        step(40);
        rd_check("R4 flag set", 2'd2, 32'h0000_0120);
        check("R7 irq high", {31'd0, irq}, 32'd1);

        // R8 pause holds the counter
        cur_req = "R8";
        run = 0;
        step(3);
        begin
            logic [31:0] held;
            addr = 2'd1; #1; held = rdata;
            step(20);
            rd_check("R8 counter held", 2'd1, held);
        end

        // R6 write 1 keeps, write 0 clears
        cur_req = "R6";
        wr(2'd2, 32'h0000_0120);
        rd_check("R6 keep", 2'd2, 32'h0000_0120);
        wr(2'd2, 32'h0000_0020);
        rd_check("R6 clear", 2'd2, 32'h0000_0020);
        check("R7 irq low after clear", {31'd0, irq}, 32'd0);

        // R7 gate off with flag set
        cur_req = "R7";
        run = 1;
        wr(2'd1, 32'd0);
        step(12);
        run = 0;
        step(2);
        wr(2'd2, 32'h0000_0100);
        rd_check("R7 flag kept", 2'd2, 32'h0000_0100);
        check("R7 irq gated", {31'd0, irq}, 32'd0);

        // R6 clearing write collides with an underflow
        cur_req = "R6";
        wr(2'd2, 32'h0000_0020);
        wr(2'd1, 32'd1);
        run = 1;
        step(1);
        wait_uf();
        wr(2'd2, 32'h0000_0020);
        rd_check("R6 underflow beats clear", 2'd2, 32'h0000_0120);

        // R5 counter load collides with an underflow
        cur_req = "R5";
        run = 0;
        step(2);
        wr(2'd2, 32'h0000_0020);
        wr(2'd1, 32'd0);
        run = 1;
        step(1);
        wait_uf();
        wr(2'd1, 32'd9);
        rd_check("R5 load wins", 2'd1, 32'd9);
        rd_check("R5 no flag", 2'd2, 32'h0000_0020);
        wr(2'd0, 32'd3);
        rd_check("R5 const only", 2'd1, 32'd9);

        // R3 every prescaler code
        cur_req = "R3";
        for (int c = 1; c < 8; c++) begin
            wr(2'd2, 32'h0000_0020 | c);
            wr(2'd1, 32'd2);
            step(m_div(c[2:0]) * 5);
        end
        run = 0;
        step(4);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule